// File: doc/BRIEF.md
# LCD panel power sequencer

This block brings an LCD panel up and down by writing, in a fixed order, to the eight-register control port of the panel's timing-generator chip. Each write is one cycle: a strobe, a 3-bit register address and an 8-bit value. The order interleaves supply enables, the common-voltage bias DAC programming and the signal-output enables. Settling gaps are measured in milliseconds, which the block counts in clock cycles. The bias DAC sits behind a two-wire serial link that is carried on two bits of a supply register. The sequencer therefore programs the DAC by toggling those bits with a run of consecutive writes to that register.

A request to power up or down is taken only while the block is idle. When it is taken, the block samples the display-mode select (VGA or QVGA), the optional phase trim and the optional bias level. It raises `busy` until the last write of the sequence. A `panelReady` flag records that a full power-up has finished. A further power-up request while the flag is set rewrites only the phase and resolution registers, which lets the display mode change without cycling the supplies.

Top module: `lps_panel_sequencer`

## Requirements
- R1: After reset, `busy`, `regWrEn` and `panelReady` are all 0, and no write is issued until a request is taken.
- R2: A full power-up writes, as (address, value): (6,1F) (3,03) (4,00) (4,04), then (3,07) (6,09), then the DAC program, then (3,17) (4,06), then (6,01) (3,1F) (4,07) (6,00), then (1,phase) (7,00), then (0,resolution). The first write appears on the second cycle after the edge that takes the request. Writes follow one per cycle except at the gaps of R3. Address 4 carries only bits 2:0, and addresses 2 and 5 are never written.
- R3: Exactly 3·CYC_PER_MS idle cycles follow the write (4,04). Exactly 2·CYC_PER_MS idle cycles follow (4,06), and exactly CYC_PER_MS idle cycles follow (7,00).
- R4: A DAC program with base value b (bits 1:0 clear) and level v is 87 consecutive writes to address 3. In these writes bit 0 is the serial clock and bit 1 the serial data. It starts with b|3, b|1, b. Then come the bytes 9C, 00 and v, MSB first. Each bit k takes three writes: b|2k, b|2k|1, b|2k. Each byte is followed by an acknowledge slot b, b|1, b. It ends with b, b|1, b|3.
- R5: On power-up the DAC level is `comLevel` when `comValid` is 1 and 125 otherwise, with base 04. On power-down the level is 0 with base 14.
- R6: The phase value is {phaseAdj,1} in VGA mode (`vgaMode`=1) with `phaseValid`=1, 01 in VGA mode without a trim, and 13 in QVGA mode. The resolution value is 00 in VGA mode and 01 in QVGA mode.
- R7: A power-up request taken while `panelReady` is 1 writes only (1,phase) and then (0,resolution). The first of these appears on the second cycle after the edge that takes the request.
- R8: A power-down starts with 34·CYC_PER_MS+2 idle busy cycles after the edge that takes it. It then writes (4,06) (6,08) (3,14), the DAC program, then (4,04) (3,04) (6,1E) (3,00) (4,00), back to back.
- R9: `panelReady` becomes 1 as `busy` falls at the end of a full power-up. It becomes 0 as `busy` falls at the end of a power-down, and it changes at no other time.
- R10: `busy` is 1 from the cycle after a request is taken up to and including the cycle of its last write. No write occurs while `busy` is 0, and requests that arrive while `busy` is 1 have no effect.
- R11: When both requests are high in the same idle cycle, the power-down is taken.
- R12: Mode, phase and bias inputs are sampled on the edge that takes a request. Changes to them while `busy` is 1 do not alter the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerUpReq | input | 1 | Request a power-up, or a phase/resolution refresh when ready |
| powerDownReq | input | 1 | Request a power-down |
| vgaMode | input | 1 | 1 selects VGA, 0 selects QVGA |
| phaseValid | input | 1 | `phaseAdj` holds a trim value |
| phaseAdj | input | 4 | Phase trim for VGA mode |
| comValid | input | 1 | `comLevel` holds a bias value |
| comLevel | input | 8 | Common-voltage bias level |
| busy | output | 1 | A sequence is running |
| panelReady | output | 1 | A full power-up has completed |
| regWrEn | output | 1 | Register write strobe |
| regAddr | output | 3 | Register address |
| regData | output | 8 | Register value |

## Verification
The hardest situation to reach is a request that arrives while a sequence is running. It becomes harder still when the settings inputs change at the same moment, because only a cycle-exact model tells whether a write reflected the new values. The stimulus therefore pulses both requests and rewrites the mode, phase and bias inputs partway through a long power-up. Every cycle of the resulting write stream is then compared with a model built from the settings captured at acceptance. The cycle in which `busy` falls is also a boundary, since a request there must still be ignored. For that reason, requests are issued on the last busy cycle as well as on the first idle one.

// File: rtl/lps_pkg.sv
package lps_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;
  localparam int MS_W   = 6;

  // register addresses of the timing-generator chip
  localparam logic [ADDR_W-1:0] REG_RES   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PHASE = 3'd1;
  localparam logic [ADDR_W-1:0] REG_PWRA  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_PWRB  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_IFACE = 3'd6;
  localparam logic [ADDR_W-1:0] REG_POL   = 3'd7;

  // supply register A: serial link and low-voltage rails
  localparam logic [DATA_W-1:0] PA_SCLK = 8'h01;
  localparam logic [DATA_W-1:0] PA_SDAT = 8'h02;
  localparam logic [DATA_W-1:0] PA_DAC  = 8'h04;
  localparam logic [DATA_W-1:0] PA_COM  = 8'h08;
  localparam logic [DATA_W-1:0] PA_V5   = 8'h10;
  localparam logic [DATA_W-1:0] PA_LINK = PA_SCLK | PA_SDAT;

  // supply register B: panel rails
  localparam logic [DATA_W-1:0] PB_VW   = 8'h01;
  localparam logic [DATA_W-1:0] PB_GATE = 8'h02;
  localparam logic [DATA_W-1:0] PB_VDD  = 8'h04;

  // interface control register
  localparam logic [DATA_W-1:0] IF_INIT   = 8'h01;
  localparam logic [DATA_W-1:0] IF_INIOFF = 8'h02;
  localparam logic [DATA_W-1:0] IF_PDWN   = 8'h04;
  localparam logic [DATA_W-1:0] IF_COMOFF = 8'h08;
  localparam logic [DATA_W-1:0] IF_DACOFF = 8'h10;

  typedef enum logic [1:0] {K_WRITE, K_PAUSE, K_DAC, K_END} stepKind_t;
  typedef enum logic [1:0] {SEQ_FULL_UP, SEQ_REFRESH, SEQ_DOWN} seqSel_t;

  typedef struct packed {
    stepKind_t           kind;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;   // write value, or DAC level
    logic [DATA_W-1:0]   aux;    // DAC base value
    logic [MS_W-1:0]     waitMs; // pause after this step
  } stepEntry_t;

  typedef struct packed {
    logic    capture;
    seqSel_t seq;
    logic    issueWrite;
    logic    issueDac;
    logic    stepNext;
    logic    loadWait;
    logic    tickWait;
  } ctrlStrobe_t;

  typedef struct packed {
    stepKind_t kind;
    logic      hasWait;
    logic      waitZero;
    logic      dacLast;
  } dpStatus_t;

  function automatic stepEntry_t mkWrite(input logic [ADDR_W-1:0] a,
                                         input logic [DATA_W-1:0] d,
                                         input logic [MS_W-1:0] ms);
    stepEntry_t e;
    e.kind = K_WRITE; e.addr = a; e.data = d; e.aux = '0; e.waitMs = ms;
    return e;
  endfunction

  function automatic stepEntry_t mkDac(input logic [DATA_W-1:0] base,
                                       input logic [DATA_W-1:0] level);
    stepEntry_t e;
    e.kind = K_DAC; e.addr = REG_PWRA; e.data = level; e.aux = base; e.waitMs = '0;
    return e;
  endfunction

  function automatic stepEntry_t mkPause(input logic [MS_W-1:0] ms);
    stepEntry_t e;
    e.kind = K_PAUSE; e.addr = '0; e.data = '0; e.aux = '0; e.waitMs = ms;
    return e;
  endfunction

endpackage

// File: rtl/lps_step_rom.sv
module lps_step_rom
  import lps_pkg::*;
#(
  parameter int VDD_SETTLE_MS  = 3,
  parameter int GATE_SETTLE_MS = 2,
  parameter int POL_SETTLE_MS  = 1,
  parameter int DRAIN_MS       = 34
) (
  input  seqSel_t            seq,
  input  logic [IDX_W-1:0]   idx,
  input  logic               vgaQ,
  input  logic [DATA_W-1:0]  phaseCode,
  input  logic [DATA_W-1:0]  comCode,
  output stepEntry_t         entry
);

  localparam logic [MS_W-1:0] MS_VDD  = MS_W'(VDD_SETTLE_MS);
  localparam logic [MS_W-1:0] MS_GATE = MS_W'(GATE_SETTLE_MS);
  localparam logic [MS_W-1:0] MS_POL  = MS_W'(POL_SETTLE_MS);
  localparam logic [MS_W-1:0] MS_DRN  = MS_W'(DRAIN_MS);
  localparam logic [MS_W-1:0] MS_NONE = '0;

  logic [DATA_W-1:0] resCode;
  assign resCode = vgaQ ? 8'h00 : 8'h01;

  always_comb begin
    entry = '0;
    entry.kind = K_END;
    case (seq)
      SEQ_FULL_UP: begin
        case (idx)
          5'd0:  entry = mkWrite(REG_IFACE, IF_INIT | IF_INIOFF | IF_PDWN | IF_COMOFF | IF_DACOFF, MS_NONE);
          5'd1:  entry = mkWrite(REG_PWRA, PA_LINK, MS_NONE);
          5'd2:  entry = mkWrite(REG_PWRB, 8'h00, MS_NONE);
          5'd3:  entry = mkWrite(REG_PWRB, PB_VDD, MS_VDD);
          5'd4:  entry = mkWrite(REG_PWRA, PA_LINK | PA_DAC, MS_NONE);
          5'd5:  entry = mkWrite(REG_IFACE, IF_INIT | IF_COMOFF, MS_NONE);
          5'd6:  entry = mkDac(PA_DAC, comCode);
          5'd7:  entry = mkWrite(REG_PWRA, PA_LINK | PA_DAC | PA_V5, MS_NONE);
          5'd8:  entry = mkWrite(REG_PWRB, PB_GATE | PB_VDD, MS_GATE);
          5'd9:  entry = mkWrite(REG_IFACE, IF_INIT, MS_NONE);
          5'd10: entry = mkWrite(REG_PWRA, PA_LINK | PA_DAC | PA_COM | PA_V5, MS_NONE);
          5'd11: entry = mkWrite(REG_PWRB, PB_VW | PB_GATE | PB_VDD, MS_NONE);
          5'd12: entry = mkWrite(REG_IFACE, 8'h00, MS_NONE);
          5'd13: entry = mkWrite(REG_PHASE, phaseCode, MS_NONE);
          5'd14: entry = mkWrite(REG_POL, 8'h00, MS_POL);
          5'd15: entry = mkWrite(REG_RES, resCode, MS_NONE);
          default: ;
        endcase
      end
      SEQ_REFRESH: begin
        case (idx)
          5'd0:  entry = mkWrite(REG_PHASE, phaseCode, MS_NONE);
          5'd1:  entry = mkWrite(REG_RES, resCode, MS_NONE);
          default: ;
        endcase
      end
      SEQ_DOWN: begin
        case (idx)
          5'd0:  entry = mkPause(MS_DRN);
          5'd1:  entry = mkWrite(REG_PWRB, PB_GATE | PB_VDD, MS_NONE);
          5'd2:  entry = mkWrite(REG_IFACE, IF_COMOFF, MS_NONE);
          5'd3:  entry = mkWrite(REG_PWRA, PA_DAC | PA_V5, MS_NONE);
          5'd4:  entry = mkDac(PA_DAC | PA_V5, 8'h00);
          5'd5:  entry = mkWrite(REG_PWRB, PB_VDD, MS_NONE);
          5'd6:  entry = mkWrite(REG_PWRA, PA_DAC, MS_NONE);
          5'd7:  entry = mkWrite(REG_IFACE, IF_INIOFF | IF_PDWN | IF_COMOFF | IF_DACOFF, MS_NONE);
          5'd8:  entry = mkWrite(REG_PWRA, 8'h00, MS_NONE);
          5'd9:  entry = mkWrite(REG_PWRB, 8'h00, MS_NONE);
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lps_dac_serializer.sv
module lps_dac_serializer
  import lps_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEV_BYTE = 8'h9C,
  parameter logic [DATA_W-1:0] CMD_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] level,
  output logic [DATA_W-1:0] elemData,
  output logic              elemLast
);

  localparam logic [2:0] G_START = 3'd0;
  localparam logic [2:0] G_STOP  = 3'd4;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [2:0] grp;     // 0 start, 1..3 bytes, 4 stop
  logic [3:0] bitIdx;  // 0..7 data bits, 8 acknowledge
  logic [1:0] ph;      // 0 low, 1 clock high, 2 low

  logic [DATA_W-1:0] curByte;
  logic [2:0]        bitPos;
  logic [DATA_W-1:0] dataLevel;

  always_comb begin
    case (grp)
      3'd1:    curByte = DEV_BYTE;
      3'd2:    curByte = CMD_BYTE;
      default: curByte = level;
    endcase
  end

  assign bitPos = 3'(4'd7 - bitIdx);

  always_comb begin
    dataLevel = base;
    if (bitIdx != ACK_SLOT && curByte[bitPos]) dataLevel = base | PA_SDAT;
  end

  always_comb begin
    if (grp == G_START) begin
      case (ph)
        2'd0:    elemData = base | PA_SCLK | PA_SDAT;
        2'd1:    elemData = base | PA_SCLK;
        default: elemData = base;
      endcase
    end else if (grp == G_STOP) begin
      case (ph)
        2'd0:    elemData = base;
        2'd1:    elemData = base | PA_SCLK;
        default: elemData = base | PA_SCLK | PA_SDAT;
      endcase
    end else begin
      elemData = (ph == 2'd1) ? (dataLevel | PA_SCLK) : dataLevel;
    end
  end

  assign elemLast = (grp == G_STOP) && (ph == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grp    <= G_START;
      bitIdx <= '0;
      ph     <= '0;
    end else if (advance) begin
      if (ph != 2'd2) begin
        ph <= ph + 2'd1;
      end else begin
        ph <= '0;
        if (grp == G_START) begin
          grp <= 3'd1;
        end else if (grp == G_STOP) begin
          grp <= G_START;
        end else if (bitIdx == ACK_SLOT) begin
          bitIdx <= '0;
          grp    <= grp + 3'd1;
        end else begin
          bitIdx <= bitIdx + 4'd1;
        end
      end
    end
  end

endmodule

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int CYC_PER_MS            = 200000,
  parameter int QVGA_PHASE            = 9,
  parameter int DEFAULT_COM           = 125,
  parameter logic [DATA_W-1:0] DEV_BYTE = 8'h9C,
  parameter logic [DATA_W-1:0] CMD_BYTE = 8'h00,
  parameter int VDD_SETTLE_MS         = 3,
  parameter int GATE_SETTLE_MS        = 2,
  parameter int POL_SETTLE_MS         = 1,
  parameter int DRAIN_MS              = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              vgaMode,
  input  logic              phaseValid,
  input  logic [3:0]        phaseAdj,
  input  logic              comValid,
  input  logic [DATA_W-1:0] comLevel,
  output dpStatus_t         status,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regData
);

  localparam int MAX_MS = (1 << MS_W) - 1;
  localparam int WAIT_W = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic              vgaQ;
  logic [DATA_W-1:0] phaseCode;
  logic [DATA_W-1:0] comCode;
  seqSel_t           seqQ;
  logic [IDX_W-1:0]  idx;
  logic [WAIT_W-1:0] waitCnt;
  logic [31:0]       waitProd;

  stepEntry_t        entry;
  logic [DATA_W-1:0] dacElem;
  logic              dacLast;
  logic [DATA_W-1:0] phaseSel;

  always_comb begin
    if (!vgaMode)        phaseSel = {3'b000, 4'(QVGA_PHASE), 1'b1};
    else if (phaseValid) phaseSel = {3'b000, phaseAdj, 1'b1};
    else                 phaseSel = 8'h01;
  end

  lps_step_rom #(
    .VDD_SETTLE_MS (VDD_SETTLE_MS),
    .GATE_SETTLE_MS(GATE_SETTLE_MS),
    .POL_SETTLE_MS (POL_SETTLE_MS),
    .DRAIN_MS      (DRAIN_MS)
  ) uRom (
    .seq      (seqQ),
    .idx      (idx),
    .vgaQ     (vgaQ),
    .phaseCode(phaseCode),
    .comCode  (comCode),
    .entry    (entry)
  );

  lps_dac_serializer #(
    .DEV_BYTE(DEV_BYTE),
    .CMD_BYTE(CMD_BYTE)
  ) uDac (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strobe.issueDac),
    .base    (entry.aux),
    .level   (entry.data),
    .elemData(dacElem),
    .elemLast(dacLast)
  );

  assign waitProd = 32'(entry.waitMs) * 32'(CYC_PER_MS);

  assign status.kind     = entry.kind;
  assign status.hasWait  = (entry.waitMs != '0);
  assign status.waitZero = (waitCnt == '0);
  assign status.dacLast  = dacLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vgaQ      <= 1'b0;
      phaseCode <= '0;
      comCode   <= '0;
      seqQ      <= SEQ_FULL_UP;
      idx       <= '0;
      waitCnt   <= '0;
      regWrEn   <= 1'b0;
      regAddr   <= '0;
      regData   <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (strobe.capture) begin
        vgaQ      <= vgaMode;
        phaseCode <= phaseSel;
        comCode   <= comValid ? comLevel : 8'(DEFAULT_COM);
        seqQ      <= strobe.seq;
        idx       <= '0;
      end
      if (strobe.stepNext) idx <= idx + 1'b1;
      if (strobe.loadWait)      waitCnt <= WAIT_W'(waitProd - 32'd1);
      else if (strobe.tickWait) waitCnt <= waitCnt - 1'b1;
      if (strobe.issueWrite) begin
        regWrEn <= 1'b1;
        regAddr <= entry.addr;
        regData <= entry.data;
      end else if (strobe.issueDac) begin
        regWrEn <= 1'b1;
        regAddr <= REG_PWRA;
        regData <= dacElem;
      end
    end
  end

endmodule

// File: rtl/lps_control.sv
module lps_control
  import lps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerUpReq,
  input  logic        powerDownReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        panelReady
);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT, S_DAC} state_t;

  state_t  state, stateNext;
  seqSel_t runSeq;
  logic    readyNext;

  always_comb begin
    strobe     = '0;
    strobe.seq = SEQ_FULL_UP;
    stateNext  = state;
    readyNext  = panelReady;
    case (state)
      S_IDLE: begin
        if (powerDownReq) begin
          strobe.capture = 1'b1;
          strobe.seq     = SEQ_DOWN;
          stateNext      = S_STEP;
        end else if (powerUpReq) begin
          strobe.capture = 1'b1;
          strobe.seq     = panelReady ? SEQ_REFRESH : SEQ_FULL_UP;
          stateNext      = S_STEP;
        end
      end
      S_STEP: begin
        case (status.kind)
          K_WRITE: begin
            strobe.issueWrite = 1'b1;
            if (status.hasWait) begin
              strobe.loadWait = 1'b1;
              stateNext       = S_WAIT;
            end else begin
              strobe.stepNext = 1'b1;
            end
          end
          K_PAUSE: begin
            strobe.loadWait = 1'b1;
            stateNext       = S_WAIT;
          end
          K_DAC: begin
            strobe.issueDac = 1'b1;
            stateNext       = S_DAC;
          end
          default: begin
            stateNext = S_IDLE;
            if (runSeq == SEQ_FULL_UP)   readyNext = 1'b1;
            else if (runSeq == SEQ_DOWN) readyNext = 1'b0;
          end
        endcase
      end
      S_WAIT: begin
        if (status.waitZero) begin
          strobe.stepNext = 1'b1;
          stateNext       = S_STEP;
        end else begin
          strobe.tickWait = 1'b1;
        end
      end
      default: begin
        strobe.issueDac = 1'b1;
        if (status.dacLast) begin
          strobe.stepNext = 1'b1;
          stateNext       = S_STEP;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      runSeq     <= SEQ_FULL_UP;
      panelReady <= 1'b0;
    end else begin
      state      <= stateNext;
      panelReady <= readyNext;
      if (strobe.capture) runSeq <= strobe.seq;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/lps_panel_sequencer.sv
module lps_panel_sequencer
  import lps_pkg::*;
#(
  parameter int CYC_PER_MS     = 200000,
  parameter int QVGA_PHASE     = 9,
  parameter int DEFAULT_COM    = 125,
  parameter int VDD_SETTLE_MS  = 3,
  parameter int GATE_SETTLE_MS = 2,
  parameter int POL_SETTLE_MS  = 1,
  parameter int DRAIN_MS       = 34
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerUpReq,
  input  logic       powerDownReq,
  input  logic       vgaMode,
  input  logic       phaseValid,
  input  logic [3:0] phaseAdj,
  input  logic       comValid,
  input  logic [7:0] comLevel,
  output logic       busy,
  output logic       panelReady,
  output logic       regWrEn,
  output logic [2:0] regAddr,
  output logic [7:0] regData
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  lps_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .powerUpReq  (powerUpReq),
    .powerDownReq(powerDownReq),
    .status      (status),
    .strobe      (strobe),
    .busy        (busy),
    .panelReady  (panelReady)
  );

  lps_datapath #(
    .CYC_PER_MS    (CYC_PER_MS),
    .QVGA_PHASE    (QVGA_PHASE),
    .DEFAULT_COM   (DEFAULT_COM),
    .VDD_SETTLE_MS (VDD_SETTLE_MS),
    .GATE_SETTLE_MS(GATE_SETTLE_MS),
    .POL_SETTLE_MS (POL_SETTLE_MS),
    .DRAIN_MS      (DRAIN_MS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .vgaMode   (vgaMode),
    .phaseValid(phaseValid),
    .phaseAdj  (phaseAdj),
    .comValid  (comValid),
    .comLevel  (comLevel),
    .status    (status),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regData   (regData)
  );

endmodule

// File: rtl/lps_checker.sv
module lps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       powerUpReq,
  input logic       powerDownReq,
  input logic       busy,
  input logic       panelReady,
  input logic       regWrEn,
  input logic [2:0] regAddr,
  input logic [7:0] regData
);

  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !regWrEn);

  assert_start_on_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(powerUpReq || powerDownReq));

  assert_ready_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(panelReady) |-> $fell(busy));

  assert_addr_map_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regAddr != 3'd2 && regAddr != 3'd5));

  assert_rail_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd4) |-> (regData[7:3] == 5'd0));

  assert_res_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0) |-> (regData[7:1] == 7'd0));

  assert_phase_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd1) |-> (regData[0] && regData[7:5] == 3'd0));

endmodule

bind lps_panel_sequencer lps_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .powerUpReq  (powerUpReq),
  .powerDownReq(powerDownReq),
  .busy        (busy),
  .panelReady  (panelReady),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regData     (regData)
);

// File: tb/tb_lps_panel_sequencer.sv
module tb_lps_panel_sequencer;

  localparam int C = 10;  // cycles per millisecond in this bench

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerUpReq = 1'b0, powerDownReq = 1'b0;
  logic       vgaMode = 1'b0, phaseValid = 1'b0, comValid = 1'b0;
  logic [3:0] phaseAdj = 4'd0;
  logic [7:0] comLevel = 8'd0;
  logic       busy, panelReady, regWrEn;
  logic [2:0] regAddr;
  logic [7:0] regData;

  always #2.5 clk = ~clk;

  lps_panel_sequencer #(.CYC_PER_MS(C)) dut (
    .clk(clk), .rstN(rstN), .powerUpReq(powerUpReq), .powerDownReq(powerDownReq),
    .vgaMode(vgaMode), .phaseValid(phaseValid), .phaseAdj(phaseAdj),
    .comValid(comValid), .comLevel(comLevel), .busy(busy), .panelReady(panelReady),
    .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData)
  );

  // reference model: one entry per expected busy cycle
  int    expQ[$];
  int    vectors = 0, errors = 0, cycleNo = 0;
  bit    expReady = 0, pendReady = 0, curBusyExp = 0;
  string curReq = "R1";

  function automatic int wItem(int a, int d);
    return (1 << 11) | (a << 8) | (d & 8'hFF);
  endfunction

  task automatic pushW(int a, int d);
    expQ.push_back(wItem(a, d));
  endtask

  task automatic pushIdle(int n);
    for (int i = 0; i < n; i++) expQ.push_back(0);
  endtask

  task automatic pushDac(int b, int lvl);
    int bytes[3];
    bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = lvl;
    pushW(3, b | 3); pushW(3, b | 1); pushW(3, b);
    for (int k = 0; k < 3; k++) begin
      for (int i = 7; i >= 0; i--) begin
        int d;
        d = b | (((bytes[k] >> i) & 1) << 1);
        pushW(3, d); pushW(3, d | 1); pushW(3, d);
      end
      pushW(3, b); pushW(3, b | 1); pushW(3, b);
    end
    pushW(3, b); pushW(3, b | 1); pushW(3, b | 3);
  endtask

  function automatic int phaseOf(bit vga, bit pv, int p);
    if (!vga) return 8'h13;
    if (pv) return ((p & 15) << 1) | 1;
    return 1;
  endfunction

  task automatic modelFullUp(bit vga, bit pv, int p, bit cv, int cl);
    pushIdle(1);
    pushW(6, 8'h1F); pushW(3, 8'h03); pushW(4, 8'h00); pushW(4, 8'h04);
    pushIdle(3 * C);
    pushW(3, 8'h07); pushW(6, 8'h09);
    pushDac(8'h04, cv ? cl : 125);
    pushW(3, 8'h17); pushW(4, 8'h06);
    pushIdle(2 * C);
    pushW(6, 8'h01); pushW(3, 8'h1F); pushW(4, 8'h07); pushW(6, 8'h00);
    pushW(1, phaseOf(vga, pv, p)); pushW(7, 8'h00);
    pushIdle(C);
    pushW(0, vga ? 0 : 1);
  endtask

  task automatic modelRefresh(bit vga, bit pv, int p);
    pushIdle(1);
    pushW(1, phaseOf(vga, pv, p));
    pushW(0, vga ? 0 : 1);
  endtask

  task automatic modelDown();
    pushIdle(34 * C + 2);
    pushW(4, 8'h06); pushW(6, 8'h08); pushW(3, 8'h14);
    pushDac(8'h14, 0);
    pushW(4, 8'h04); pushW(3, 8'h04); pushW(6, 8'h1E); pushW(3, 8'h00); pushW(4, 8'h00);
  endtask

  // one clock: compare at the falling edge against the model
  task automatic tick();
    int  e;
    bit  eb, ew, had;
    @(negedge clk);
    cycleNo++;
    vectors++;
    had = (expQ.size() != 0);
    if (had) begin e = expQ.pop_front(); eb = 1; ew = e[11]; end
    else begin e = 0; eb = 0; ew = 0; end
    if (busy !== eb || regWrEn !== ew || panelReady !== expReady ||
        (ew && (regAddr !== 3'(e >> 8) || regData !== 8'(e)))) begin
      errors++;
      $display("FAIL %s cycle %0d: actual busy=%b wr=%b addr=%0d data=%h ready=%b expected busy=%b wr=%b addr=%0d data=%h ready=%b",
               curReq, cycleNo, busy, regWrEn, regAddr, regData, panelReady,
               eb, ew, (e >> 8) & 7, e & 8'hFF, expReady);
    end
    if (had && expQ.size() == 0) expReady = pendReady;
    curBusyExp = eb;
  endtask

  // drive a one-cycle request; the model takes it only if the block is idle now
  task automatic request(bit up, bit down);
    powerUpReq = up; powerDownReq = down;
    if (!curBusyExp) begin
      if (down) begin modelDown(); pendReady = 0; end
      else if (up) begin
        if (expReady) modelRefresh(vgaMode, phaseValid, phaseAdj);
        else modelFullUp(vgaMode, phaseValid, phaseAdj, comValid, comLevel);
        pendReady = 1;
      end
    end
    tick();
    powerUpReq = 0; powerDownReq = 0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) tick();
    tick(); tick();
  endtask

  task automatic settings(bit vga, bit pv, int p, bit cv, int cl);
    vgaMode = vga; phaseValid = pv; phaseAdj = 4'(p); comValid = cv; comLevel = 8'(cl);
  endtask

  initial begin
    // R1: reset values, during and after reset
    curReq = "R1";
    tick(); tick();
    rstN = 1'b1;
    tick(); tick(); tick();

    // R11: both requests at once from idle, power-down wins; R8 lead pause and order
    curReq = "R11/R8";
    request(1, 1);
    drain();

    // R2, R3, R4, R5, R6: full power-up in QVGA with no trims supplied
    curReq = "R2/R3/R4/R5/R6";
    settings(0, 0, 0, 0, 0);
    request(1, 0);
    repeat (20) tick();
    // R10, R12: requests and new settings while busy change nothing
    curReq = "R10/R12";
    settings(1, 1, 5, 1, 8'h33);
    request(1, 0);
    request(0, 1);
    repeat (60) tick();
    request(1, 1);
    while (expQ.size() > 1) tick();
    request(0, 1);   // lands on the last busy cycle: ignored
    curReq = "R9";
    tick(); tick();

    // R7, R6: refresh while ready, VGA with a trim
    curReq = "R7/R6";
    settings(1, 1, 4'hA, 1, 8'h44);
    request(1, 0);
    drain();
    // R6: VGA without a trim, then QVGA
    curReq = "R6";
    settings(1, 0, 4'hF, 0, 0);
    request(1, 0);
    drain();
    settings(0, 1, 4'h3, 0, 0);
    request(1, 0);
    drain();

    // R8, R9, R5: power-down clears ready, DAC level 0
    curReq = "R8/R9/R5";
    request(0, 1);
    drain();

    // R4, R5: full power-up in VGA with supplied trim and bias
    curReq = "R4/R5/R2";
    settings(1, 1, 4'hF, 1, 8'h5A);
    request(1, 0);
    drain();
    curReq = "R8";
    request(0, 1);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule